// File: doc/BRIEF.md
# DMA Request Conditioning and Channel Arbiter

This block is the front end of a multi-channel DMA engine. For every channel it works out whether a transfer request is present and then chooses which channel the engine serves next. A channel's request can come from an external request pin, from an on-chip peripheral request line, or from an automatic request that is present whenever the channel is enabled. An external pin passes through a two-stage synchronizer. Each channel then senses it as a low level, a high level, a rising edge or a falling edge. An edge is held as pending until that channel is granted.

The enabled and requesting channels are arbitrated under one of two priority schemes, picked by a global switch. In fixed priority the lowest channel number wins. In round-robin the search starts one channel above the channel granted last. The winner receives a one-hot grant that stays active until the transfer engine reports completion. The winner also receives a single-cycle acknowledge pulse on the first cycle of that grant, which is when its bus access begins. Only the low-numbered channels, up to a parameter, have a request pin.

Top module: `dma_req_arbiter`

## Requirements
- R1: While and after synchronous reset, `grant`, `grant_valid`, `grant_ch` and `dack` are all zero and no edge is pending. The round-robin pointer starts so that channel 0 is searched first.
- R2: Each channel's 2-bit field `ch_src[2*i+1:2*i]` selects the request source: 0 = automatic (request whenever enabled), 1 = `periph_req[i]`, 2 = external pin, 3 = no request. A channel whose `ch_enable` bit is low never requests.
- R3: Only channels below `NUM_EXT` have an external pin. A higher channel set to source 2 never requests.
- R4: Each channel's 2-bit field `dreq_sense[2*i+1:2*i]` selects how its pin is sensed: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Sensing acts on the pin after two synchronizer flops. A level change driven before clock edge k produces a grant at edge k+2. An edge produces a grant at edge k+3.
- R5: A detected edge is held pending while the channel is busy elsewhere. The pending edge is cleared when that channel is granted, and it is discarded whenever the channel is disabled.
- R6: With `rr_mode` = 0, the requesting channel with the lowest number wins.
- R7: With `rr_mode` = 1, the search starts at the channel one above the channel granted last and wraps around. Every grant updates the pointer, in either mode.
- R8: `grant` is one-hot and is held, together with `grant_valid` and `grant_ch`, until `xfer_done` is sampled high. The next grant can appear one cycle after the release.
- R9: `dack` pulses for exactly one cycle, on the first cycle of a grant, on the granted channel's bit.
- R10: An automatic or peripheral request present at a clock edge while no grant is held produces the grant at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_src | input | 2*NUM_CH | Per-channel request source code |
| dreq_sense | input | 2*NUM_CH | Per-channel pin sensing code |
| rr_mode | input | 1 | 1 = round-robin, 0 = fixed priority |
| periph_req | input | NUM_CH | On-chip peripheral request lines |
| dreq_pin | input | NUM_EXT | Asynchronous external request pins |
| xfer_done | input | 1 | Transfer engine releases the current grant |
| grant | output | NUM_CH | One-hot grant, held until release |
| grant_valid | output | 1 | A grant is held |
| grant_ch | output | $clog2(NUM_CH) | Number of the granted channel, zero when idle |
| dack | output | NUM_CH | One-cycle acknowledge on the first grant cycle |

## Verification
The bench builds the block with `NUM_CH` = 8 and `NUM_EXT` = 3, so that channels 3 to 7 have no pin. This setting lets the bench show that an external source on such a channel stays silent. It also makes round-robin wrap from channel 6 to channel 2 across an eight-entry ring. Edge requests are held pending behind a long grant on channel 7, which exposes the clear-on-grant and the discard-on-disable behaviour. A per-cycle reference model also checks synchronizer latency for both level and edge sensing.

// File: rtl/dmaarb_pkg.sv
`timescale 1ns/1ps
package dmaarb_pkg;

    typedef enum logic [1:0] {
        SRC_AUTO   = 2'd0,
        SRC_PERIPH = 2'd1,
        SRC_EXT    = 2'd2,
        SRC_NONE   = 2'd3
    } req_src_e;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_HIGH = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_FALL = 2'd3
    } sense_e;

    function automatic logic sense_is_edge(sense_e m);
        return (m == SENSE_RISE) || (m == SENSE_FALL);
    endfunction

    function automatic logic select_req(req_src_e s, logic en, logic pr, logic ex);
        logic r;
        case (s)
            SRC_AUTO:   r = 1'b1;
            SRC_PERIPH: r = pr;
            SRC_EXT:    r = ex;
            default:    r = 1'b0;
        endcase
        return en & r;
    endfunction

endpackage

// File: rtl/dmaarb_dreq_sense.sv
`timescale 1ns/1ps
module dmaarb_dreq_sense
    import dmaarb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin,
    input  logic   chan_en,
    input  logic   ext_sel,
    input  sense_e mode,
    input  logic   take,
    output logic   req
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              pend_q;
    logic              pend_d;
    logic              lvl;
    logic              edge_hit;
    logic              edge_set;

    assign lvl = sync_q[STAGES-1];

    always_comb begin
        case (mode)
            SENSE_RISE: edge_hit = lvl & ~prev_q;
            SENSE_FALL: edge_hit = ~lvl & prev_q;
            default:    edge_hit = 1'b0;
        endcase
        edge_set = chan_en & ext_sel & edge_hit;
        pend_d   = chan_en ? ((pend_q & ~take) | edge_set) : 1'b0;
        case (mode)
            SENSE_LOW:  req = ~lvl;
            SENSE_HIGH: req = lvl;
            default:    req = pend_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= lvl;
            pend_q <= pend_d;
        end
    end

    // R5: a disabled channel holds no pending edge
    assert_pend_drop_R5: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !pend_q)
        else $error("pending edge survived disable");

    // R5: pending only arises on an enabled external channel
    assert_pend_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(chan_en && ext_sel && sense_is_edge(mode)))
        else $error("pending edge without external edge source");

endmodule

// File: rtl/dmaarb_pick.sv
`timescale 1ns/1ps
module dmaarb_pick #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic [NUM_CH-1:0] req,
    input  logic              rr_mode,
    input  logic [CH_W-1:0]   last,
    output logic              found,
    output logic [CH_W-1:0]   win
);
    always_comb begin
        int start;
        start = rr_mode ? int'(last) + 1 : 0;
        if (start >= NUM_CH) start = 0;
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            int idx;
            idx = start + k;
            if (idx >= NUM_CH) idx = idx - NUM_CH;
            if (!found && req[idx]) begin
                found = 1'b1;
                win   = CH_W'(idx);
            end
        end
    end

    always_comb begin
        assert_win_requested_R6: assert (!found || req[win])
            else $error("winner is not requesting");
        assert_fixed_lowest_R6: assert (!found || rr_mode ||
            ((req & ((NUM_CH'(1) << win) - NUM_CH'(1))) == '0))
            else $error("fixed priority skipped a lower channel");
    end

endmodule

// File: rtl/dma_req_arbiter.sv
`timescale 1ns/1ps
module dma_req_arbiter
    import dmaarb_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int NUM_EXT     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CH-1:0]   ch_enable,
    input  logic [2*NUM_CH-1:0] ch_src,
    input  logic [2*NUM_CH-1:0] dreq_sense,
    input  logic                rr_mode,
    input  logic [NUM_CH-1:0]   periph_req,
    input  logic [NUM_EXT-1:0]  dreq_pin,
    input  logic                xfer_done,
    output logic [NUM_CH-1:0]   grant,
    output logic                grant_valid,
    output logic [CH_W-1:0]     grant_ch,
    output logic [NUM_CH-1:0]   dack
);
    logic [NUM_CH-1:0] ext_req;
    logic [NUM_CH-1:0] req_vec;
    logic [NUM_CH-1:0] take;
    logic              found;
    logic [CH_W-1:0]   win;
    logic              go;

    logic              busy_q;
    logic [NUM_CH-1:0] grant_q;
    logic [CH_W-1:0]   gch_q;
    logic [NUM_CH-1:0] dack_q;
    logic [CH_W-1:0]   last_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        req_src_e src_i;
        assign src_i = req_src_e'(ch_src[2*i +: 2]);
        if (i < NUM_EXT) begin : g_pin
            dmaarb_dreq_sense #(.STAGES(SYNC_STAGES)) u_sense (
                .clk     (clk),
                .rst     (rst),
                .pin     (dreq_pin[i]),
                .chan_en (ch_enable[i]),
                .ext_sel (src_i == SRC_EXT),
                .mode    (sense_e'(dreq_sense[2*i +: 2])),
                .take    (take[i]),
                .req     (ext_req[i])
            );
        end else begin : g_nopin
            assign ext_req[i] = 1'b0;
        end
        assign req_vec[i] = select_req(src_i, ch_enable[i], periph_req[i], ext_req[i]);
    end

    dmaarb_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .req     (req_vec),
        .rr_mode (rr_mode),
        .last    (last_q),
        .found   (found),
        .win     (win)
    );

    assign go   = !busy_q && found;
    assign take = go ? (NUM_CH'(1) << win) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            grant_q <= '0;
            gch_q   <= '0;
            dack_q  <= '0;
            last_q  <= CH_W'(NUM_CH - 1);
        end else begin
            dack_q <= take;
            if (go) begin
                busy_q  <= 1'b1;
                grant_q <= take;
                gch_q   <= win;
                last_q  <= win;
            end else if (busy_q && xfer_done) begin
                busy_q  <= 1'b0;
                grant_q <= '0;
                gch_q   <= '0;
            end
        end
    end

    assign grant       = grant_q;
    assign grant_valid = busy_q;
    assign grant_ch    = gch_q;
    assign dack        = dack_q;

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q) && (busy_q == (grant_q != '0)))
        else $error("grant not one-hot or disagrees with valid");

    assert_grant_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !xfer_done) |=> (busy_q && $stable(grant_q) && $stable(gch_q)))
        else $error("grant changed before release");

    assert_dack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (dack_q != '0) |=> (dack_q == '0))
        else $error("dack longer than one cycle");

    assert_dack_match_R9: assert property (@(posedge clk) disable iff (rst)
        (dack_q != '0) |-> (dack_q == grant_q))
        else $error("dack on a channel other than the grant");

    assert_grant_enabled_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> ((grant_q & $past(ch_enable)) == grant_q))
        else $error("grant to a disabled channel");

endmodule

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;
    localparam int NC = 8;
    localparam int NE = 3;
    localparam int CW = $clog2(NC);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] ch_enable = '0;
    logic [2*NC-1:0] ch_src = '0;
    logic [2*NC-1:0] dreq_sense = '0;
    logic          rr_mode = 1'b0;
    logic [NC-1:0] periph_req = '0;
    logic [NE-1:0] dreq_pin = '0;
    logic          xfer_done = 1'b0;
    logic [NC-1:0] grant;
    logic          grant_valid;
    logic [CW-1:0] grant_ch;
    logic [NC-1:0] dack;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R1";

    dma_req_arbiter #(.NUM_CH(NC), .NUM_EXT(NE)) dut_i (
        .clk(clk), .rst(rst), .ch_enable(ch_enable), .ch_src(ch_src),
        .dreq_sense(dreq_sense), .rr_mode(rr_mode), .periph_req(periph_req),
        .dreq_pin(dreq_pin), .xfer_done(xfer_done), .grant(grant),
        .grant_valid(grant_valid), .grant_ch(grant_ch), .dack(dack)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_s1[NE], m_s2[NE], m_pv[NE], m_pd[NE];
    bit m_busy;
    int m_gch, m_dack, m_last;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NE; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_pd[i] = 0;
            end
            m_busy = 0; m_gch = 0; m_dack = -1; m_last = NC - 1;
        end else begin
            bit r[NC];
            int w, st;
            for (int i = 0; i < NC; i++) begin
                int s, md;
                s = int'(ch_src[2*i +: 2]);
                md = int'(dreq_sense[2*i +: 2]);
                r[i] = 0;
                if (ch_enable[i]) begin
                    if (s == 0) r[i] = 1;
                    else if (s == 1) r[i] = periph_req[i];
                    else if (s == 2 && i < NE) begin
                        if (md == 0) r[i] = (m_s2[i] == 0);
                        else if (md == 1) r[i] = (m_s2[i] == 1);
                        else r[i] = (m_pd[i] == 1);
                    end
                end
            end
            w = -1;
            if (!m_busy) begin
                st = rr_mode ? (m_last + 1) % NC : 0;
                for (int k = 0; k < NC; k++)
                    if (w < 0 && r[(st + k) % NC]) w = (st + k) % NC;
            end
            for (int i = 0; i < NE; i++) begin
                int md; bit ed;
                md = int'(dreq_sense[2*i +: 2]);
                ed = (md == 2 && m_s2[i] == 1 && m_pv[i] == 0) ||
                     (md == 3 && m_s2[i] == 0 && m_pv[i] == 1);
                if (!ch_enable[i]) m_pd[i] = 0;
                else m_pd[i] = ((m_pd[i] == 1 && w != i) ||
                                (ed && int'(ch_src[2*i +: 2]) == 2)) ? 1 : 0;
            end
            if (m_busy) begin
                m_dack = -1;
                if (xfer_done) begin m_busy = 0; m_gch = 0; end
            end else if (w >= 0) begin
                m_busy = 1; m_gch = w; m_dack = w; m_last = w;
            end else m_dack = -1;
            for (int i = 0; i < NE; i++) begin
                m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = dreq_pin[i];
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            int eg, ed;
            eg = m_busy ? (1 << m_gch) : 0;
            ed = (m_dack >= 0) ? (1 << m_dack) : 0;
            chk(int'(grant) == eg, cur_req, "model grant", int'(grant), eg);
            chk(grant_valid == m_busy, cur_req, "model grant_valid", grant_valid, m_busy);
            chk(int'(grant_ch) == m_gch, cur_req, "model grant_ch", int'(grant_ch), m_gch);
            chk(int'(dack) == ed, cur_req, "model dack", int'(dack), ed);
        end
    end

    task automatic set_ch(input int i, input bit en, input int src, input int sense);
        ch_enable[i] = en;
        ch_src[2*i +: 2] = 2'(src);
        dreq_sense[2*i +: 2] = 2'(sense);
    endtask

    task automatic release_grant();
        @(negedge clk) xfer_done = 1'b1;
        @(negedge clk) xfer_done = 1'b0;
    endtask

    task automatic serve(input int exp, input string req);
        int t; bit fresh;
        t = 0; fresh = 0;
        while (!grant_valid && t < 40) begin
            @(posedge clk); #1; t++; fresh = 1;
        end
        chk(grant_valid && int'(grant_ch) == exp, req, "granted channel",
            grant_valid ? int'(grant_ch) : -1, exp);
        if (fresh && grant_valid) begin
            chk(dack == grant, "R9", "dack on first grant cycle", int'(dack), int'(grant));
            @(posedge clk); #1;
            chk(dack == '0, "R9", "dack one cycle later", int'(dack), 0);
        end
        release_grant();
    endtask

    task automatic drain();
        @(negedge clk);
        ch_enable = '0; periph_req = '0;
        if (grant_valid) begin
            xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(grant_valid == 0 && grant == '0 && dack == '0 && grant_ch == '0,
            "R1", "outputs in reset", int'(grant), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(grant_valid == 0, "R1", "idle after reset", grant_valid, 0);

        // R6 fixed priority: auto on 2,5,6
        cur_req = "R6";
        set_ch(2, 1, 0, 0); set_ch(5, 1, 0, 0); set_ch(6, 1, 0, 0);
        serve(2, "R6");
        serve(2, "R6");
        drain();

        // R7 round robin: last granted was 2
        cur_req = "R7";
        rr_mode = 1'b1;
        set_ch(2, 1, 0, 0); set_ch(5, 1, 0, 0); set_ch(6, 1, 0, 0);
        serve(5, "R7");
        serve(6, "R7");
        serve(2, "R7");
        serve(5, "R7");
        drain();
        rr_mode = 1'b0;

        // R2 peripheral source and disabled-by-code source
        cur_req = "R2";
        set_ch(0, 1, 3, 0); set_ch(1, 1, 1, 0); set_ch(4, 1, 1, 0);
        periph_req = 8'b0001_0000;
        serve(4, "R2");
        drain();
        chk(grant_valid == 0, "R2", "no grant with all channels disabled", grant_valid, 0);

        // R10 same-edge grant for a peripheral request
        cur_req = "R10";
        set_ch(1, 1, 1, 0);
        periph_req[1] = 1'b1;
        @(posedge clk); #1;
        chk(grant_valid && grant_ch == 1, "R10", "grant at first edge",
            int'(grant_ch), 1);
        drain();

        // R4 high level sensing and synchronizer latency
        cur_req = "R4";
        set_ch(0, 1, 2, 1);
        repeat (4) @(negedge clk);
        chk(grant_valid == 0, "R4", "no grant while pin low in high mode", grant_valid, 0);
        dreq_pin[0] = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(grant_valid == 0, "R4", "no grant after two edges", grant_valid, 0);
        @(posedge clk); #1;
        chk(grant_valid && grant_ch == 0, "R4", "grant at third edge", int'(grant_ch), 0);
        dreq_pin[0] = 1'b0;
        drain();

        // R4 low level sensing
        dreq_pin[1] = 1'b1;
        repeat (4) @(negedge clk);
        set_ch(1, 1, 2, 0);
        repeat (6) @(negedge clk);
        chk(grant_valid == 0, "R4", "no grant while pin high in low mode", grant_valid, 0);
        dreq_pin[1] = 1'b0;
        serve(1, "R4");
        drain();

        // R5 rising edge held pending behind a grant on channel 7
        cur_req = "R5";
        set_ch(7, 1, 0, 0);
        set_ch(2, 1, 2, 2);
        repeat (3) @(negedge clk);
        chk(grant_valid && grant_ch == 7, "R5", "channel 7 holds grant", int'(grant_ch), 7);
        dreq_pin[2] = 1'b1;
        repeat (2) @(negedge clk);
        dreq_pin[2] = 1'b0;
        repeat (5) @(negedge clk);
        release_grant();
        serve(2, "R5");
        serve(7, "R5");
        // pending discarded by disable
        repeat (2) @(negedge clk);
        dreq_pin[2] = 1'b1;
        repeat (2) @(negedge clk);
        dreq_pin[2] = 1'b0;
        repeat (5) @(negedge clk);
        ch_enable[2] = 1'b0;
        @(negedge clk);
        ch_enable[2] = 1'b1;
        repeat (2) @(negedge clk);
        release_grant();
        serve(7, "R5");

        // R4 falling edge: rise ignored, fall detected
        cur_req = "R4";
        repeat (2) @(negedge clk);
        set_ch(2, 1, 2, 3);
        dreq_pin[2] = 1'b1;
        repeat (5) @(negedge clk);
        release_grant();
        serve(7, "R4");
        repeat (2) @(negedge clk);
        dreq_pin[2] = 1'b0;
        repeat (5) @(negedge clk);
        release_grant();
        serve(2, "R4");
        drain();

        // R3 channel without a pin set to external
        cur_req = "R3";
        set_ch(5, 1, 2, 1);
        set_ch(4, 1, 2, 0);
        repeat (8) @(negedge clk);
        chk(grant_valid == 0, "R3", "pinless external channels silent", grant_valid, 0);
        set_ch(5, 1, 0, 0);
        serve(5, "R3");
        drain();

        // R8 grant held until release
        cur_req = "R8";
        set_ch(3, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(grant == 8'b0000_1000, "R8", "grant held", int'(grant), 8);
        repeat (10) @(negedge clk);
        chk(grant == 8'b0000_1000, "R8", "grant still held", int'(grant), 8);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(grant_valid == 0, "R8", "released for one cycle", grant_valid, 0);
        @(negedge clk);
        chk(grant_valid == 1, "R8", "regranted next cycle", grant_valid, 1);
        drain();

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule